// File: doc/BRIEF.md
# Memory-to-Memory DMA Channel Sequencer

This block is a single DMA channel. Software programs a source address, a destination address and a 32-bit control word over a small register bus. Setting the enable bit (bit 31) from 0 to 1 copies the programmed addresses into working address registers and decodes the channel's options:
- how each address steps,
- the unit width,
- the repeat flag,
- the start trigger.

The channel then copies units from source to destination, one read followed by one write per unit, through a plain request/acknowledge memory port. While it copies, it holds the CPU off the bus with a halt request.

The transfer can run in one go, started immediately, or in bounded slices. In the bounded mode a FIFO-request input starts each slice, and each slice moves at most a fixed number of units. The remaining count survives between slices, so a partly finished transfer resumes where it stopped. A stall input can hold the sequencer between units without losing any state. When the last unit is written, the channel pulses a done interrupt. It then clears its enable bit, unless it was armed to repeat.

The sequencer has six states:
- IDLE waits for a start.
- SETUP loads the counts and applies address reloads.
- READ issues the source read.
- WRITE issues the destination write.
- HOLD waits out a stall.
- END closes an activation.

The transitions are:
- IDLE→SETUP on an immediate kick or a FIFO request.
- SETUP→READ always.
- READ→WRITE on acknowledge.
- WRITE→END on acknowledge of the activation's last unit.
- WRITE→HOLD on acknowledge with stall high.
- WRITE→READ on acknowledge otherwise.
- HOLD→READ when stall falls.
- END→IDLE always.

Top module: `dma_chan_seq`

## Requirements
- R1: After reset the control word reads 0, and mem_req, cpu_halt and done_irq are low.
- R2: reg_sel selects the register written: 0 is the source, 1 is the destination, 2 is control. Only a 0-to-1 change of control bit 31 latches the working addresses and decodes the options. Rewriting control while bit 31 stays 1 neither restarts nor lengthens the transfer.
- R3: Control bits 22:21 select the destination step and bits 24:23 the source step. The codes are 00 increment, 01 decrement, 10 fixed, and 11 increment with the working address reloaded from the programmed register at the start of every activation.
- R4: Control bit 26 = 0 moves 16-bit units with a 2-byte step, mem_wide low, and mem_wdata[31:16] zero. Bit 26 = 1 moves 32-bit units with a 4-byte step.
- R5: The unit count is control[CNT_W-1:0]; higher bits are ignored. A count of zero means 2^CNT_W units.
- R6: Trigger code control[29:27] = 0 starts the transfer right after the enabling write. Code 7 starts one activation per fifo_req sampled high while the channel is enabled and idle. Any other code never starts.
- R7: With code 7 an activation moves at most FIFO_CHUNK units. The remainder is kept, and the next activation continues from the current addresses without reloading the count.
- R8: mem_first is high on both accesses of the first unit of each activation and low on all other accesses.
- R9: cpu_halt is high from the cycle after an activation starts until the activation's last unit is written. It is low between activations.
- R10: stall is sampled when a unit's write is acknowledged. While it is high, no further access is issued; the next unit resumes from the same addresses once it falls. The first unit of an activation is not held.
- R11: When the remaining count reaches zero, done_irq pulses for one cycle. Bit 31 is cleared unless bit 25 (repeat) is set with a nonzero trigger code; with repeat, the next trigger reloads the count.
- R12: Each access keeps mem_req, mem_addr and mem_we steady until mem_ack, which completes it in the same cycle. A unit is a read from the source followed by a write of that data to the destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 source, 1 destination, 2 control |
| reg_wdata | input | 32 | Register write data |
| ctrl_rdata | output | 32 | Current control word |
| fifo_req | input | 1 | Activation request for trigger code 7 |
| stall | input | 1 | Hold between units |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_wide | output | 1 | 1 for 32-bit access, 0 for 16-bit |
| mem_first | output | 1 | First unit of an activation (non-sequential) |
| mem_addr | output | ADDR_W | Access byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, 16-bit reads in bits 15:0 |
| mem_ack | input | 1 | Access completes this cycle |
| cpu_halt | output | 1 | CPU halt request |
| done_irq | output | 1 | One-cycle end-of-transfer pulse |

## Verification
The scoreboard predicts every write's address, data and first-unit flag. It catches a wrong step decode, a missed reload in mode 11, or a slice that restarts its addresses or count. Those faults show up as shifted or repeated destinations. A zero count must yield exactly 2^CNT_W writes, and a count above the mask must be truncated; a design that mishandled either would write the wrong number of units.

A rewrite of control during a transfer must add no writes, where a level-sensitive enable would restart the copy. A held stall must leave one write done, halt high and no request; a design that ignored it would race ahead. Chunked slices must keep enable set, drop halt between slices and give a single done pulse. With repeat, enable must stay set and the count must reload.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

    typedef enum logic [1:0] {
        STEP_INC = 2'b00,
        STEP_DEC = 2'b01,
        STEP_FIX = 2'b10,
        STEP_RLD = 2'b11
    } step_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_READ,
        ST_WRITE,
        ST_HOLD,
        ST_END
    } state_e;

    typedef struct packed {
        logic [2:0] trig;
        logic       wide;
        logic       rpt;
        step_e      src_step;
        step_e      dst_step;
    } cfg_t;

    localparam int         EN_BIT    = 31;
    localparam int         FIELD_LSB = 21;
    localparam int         FIELD_MSB = 29;
    localparam logic [2:0] TRIG_NOW  = 3'd0;
    localparam logic [2:0] TRIG_FIFO = 3'd7;
    localparam logic [1:0] SEL_SRC   = 2'd0;
    localparam logic [1:0] SEL_DST   = 2'd1;
    localparam logic [1:0] SEL_CTRL  = 2'd2;

endpackage

// File: rtl/dma_ctl_decode.sv
module dma_ctl_decode
    import dma_chan_pkg::*;
(
    input  logic [8:0] field_i,
    output cfg_t       cfg_o
);
    // field_i holds control bits 29:21
    always_comb begin
        cfg_o.dst_step = step_e'(field_i[1:0]);
        cfg_o.src_step = step_e'(field_i[3:2]);
        cfg_o.rpt      = field_i[4];
        cfg_o.wide     = field_i[5];
        cfg_o.trig     = field_i[8:6];
    end
endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
    import dma_chan_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              latch_i,
    input  logic              reload_i,
    input  logic              advance_i,
    input  step_e             step_i,
    input  logic              wide_i,
    input  logic [ADDR_W-1:0] prog_i,
    output logic [ADDR_W-1:0] addr_o
);
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] delta;

    assign delta  = wide_i ? ADDR_W'(4) : ADDR_W'(2);
    assign addr_o = addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (latch_i) begin
            addr_q <= prog_i;
        end else if (reload_i) begin
            if (step_i == STEP_RLD) begin
                addr_q <= prog_i;
            end
        end else if (advance_i) begin
            unique case (step_i)
                STEP_INC, STEP_RLD: addr_q <= addr_q + delta;
                STEP_DEC:           addr_q <= addr_q - delta;
                STEP_FIX:           addr_q <= addr_q;
                default:            addr_q <= addr_q;
            endcase
        end
    end
endmodule

// File: rtl/dma_unit_counter.sv
module dma_unit_counter #(
    parameter int CNT_W = 21,
    parameter int CHUNK = 112
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             fresh_i,
    input  logic             chunked_i,
    input  logic             dec_i,
    input  logic [CNT_W-1:0] raw_i,
    output logic             iter_last_o,
    output logic             rem_zero_o
);
    localparam int          CW       = CNT_W + 1;
    localparam logic [31:0] CHUNK32  = 32'(CHUNK);
    localparam logic [CW-1:0] FULL   = CW'(1) << CNT_W;

    logic [CW-1:0] rem_q;
    logic [CW-1:0] iter_q;
    logic [CW-1:0] rem_eff;
    logic [CW-1:0] iter_eff;

    always_comb begin
        if (fresh_i) begin
            rem_eff = (raw_i == '0) ? FULL : {1'b0, raw_i};
        end else begin
            rem_eff = rem_q;
        end
        if (chunked_i && ({{(32-CW){1'b0}}, rem_eff} > CHUNK32)) begin
            iter_eff = CW'(CHUNK);
        end else begin
            iter_eff = rem_eff;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q  <= '0;
            iter_q <= '0;
        end else if (load_i) begin
            rem_q  <= rem_eff;
            iter_q <= iter_eff;
        end else if (dec_i) begin
            rem_q  <= rem_q - CW'(1);
            iter_q <= iter_q - CW'(1);
        end
    end

    assign iter_last_o = (iter_q == CW'(1));
    assign rem_zero_o  = (rem_q == '0);
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
    import dma_chan_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int CNT_W      = 21,
    parameter int FIFO_CHUNK = 112
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_sel,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       ctrl_rdata,
    input  logic              fifo_req,
    input  logic              stall,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_wide,
    output logic              mem_first,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    input  logic              mem_ack,
    output logic              cpu_halt,
    output logic              done_irq
);
    localparam int N_PTR = 2;   // 0 = source, 1 = destination

    state_e            state_q, state_d;
    logic [31:0]       ctrl_q;
    logic [ADDR_W-1:0] src_prog_q, dst_prog_q;
    cfg_t              cfg_q, cfg_new;
    logic              kick_q;
    logic              busy_q;
    logic              first_q;
    logic [31:0]       data_q;

    logic              en_rise;
    logic              start;
    logic              unit_done;
    logic              iter_last;
    logic              rem_zero;
    logic              keep_en;

    logic [ADDR_W-1:0] prog_a [N_PTR];
    step_e             step_a [N_PTR];
    logic [ADDR_W-1:0] cur_a  [N_PTR];

    // ---------------- decode of the incoming control word ----------------
    dma_ctl_decode u_dec (
        .field_i (reg_wdata[FIELD_MSB:FIELD_LSB]),
        .cfg_o   (cfg_new)
    );

    assign en_rise   = reg_we && (reg_sel == SEL_CTRL) &&
                       !ctrl_q[EN_BIT] && reg_wdata[EN_BIT];
    assign start     = (state_q == ST_IDLE) && ctrl_q[EN_BIT] &&
                       (kick_q || ((cfg_q.trig == TRIG_FIFO) && fifo_req));
    assign unit_done = (state_q == ST_WRITE) && mem_ack;
    assign keep_en   = cfg_q.rpt && (cfg_q.trig != TRIG_NOW);

    // ---------------- working address generators ----------------
    assign prog_a[0] = src_prog_q;
    assign prog_a[1] = dst_prog_q;
    assign step_a[0] = cfg_q.src_step;
    assign step_a[1] = cfg_q.dst_step;

    for (genvar g = 0; g < N_PTR; g++) begin : g_ptr
        dma_addr_gen #(.ADDR_W(ADDR_W)) u_ag (
            .clk       (clk),
            .rst_n     (rst_n),
            .latch_i   (en_rise),
            .reload_i  (state_q == ST_SETUP),
            .advance_i (unit_done),
            .step_i    (step_a[g]),
            .wide_i    (cfg_q.wide),
            .prog_i    (prog_a[g]),
            .addr_o    (cur_a[g])
        );
    end

    // ---------------- unit counters ----------------
    dma_unit_counter #(.CNT_W(CNT_W), .CHUNK(FIFO_CHUNK)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (state_q == ST_SETUP),
        .fresh_i     (!busy_q),
        .chunked_i   (cfg_q.trig == TRIG_FIFO),
        .dec_i       (unit_done),
        .raw_i       (ctrl_q[CNT_W-1:0]),
        .iter_last_o (iter_last),
        .rem_zero_o  (rem_zero)
    );

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_SETUP;
            ST_SETUP: state_d = ST_READ;
            ST_READ:  if (mem_ack) state_d = ST_WRITE;
            ST_WRITE: begin
                if (mem_ack) begin
                    if (iter_last)  state_d = ST_END;
                    else if (stall) state_d = ST_HOLD;
                    else            state_d = ST_READ;
                end
            end
            ST_HOLD:  if (!stall) state_d = ST_READ;
            ST_END:   state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // ---------------- registers and channel bookkeeping ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q     <= '0;
            src_prog_q <= '0;
            dst_prog_q <= '0;
            cfg_q      <= '0;
            kick_q     <= 1'b0;
            busy_q     <= 1'b0;
            first_q    <= 1'b0;
            data_q     <= '0;
        end else begin
            if (reg_we) begin
                unique case (reg_sel)
                    SEL_SRC:  src_prog_q <= reg_wdata[ADDR_W-1:0];
                    SEL_DST:  dst_prog_q <= reg_wdata[ADDR_W-1:0];
                    SEL_CTRL: ctrl_q     <= reg_wdata;
                    default:  ;
                endcase
            end
            if (en_rise) begin
                cfg_q  <= cfg_new;
                kick_q <= (cfg_new.trig == TRIG_NOW);
            end else if (state_q == ST_SETUP) begin
                kick_q <= 1'b0;
            end
            if (state_q == ST_SETUP) begin
                busy_q  <= 1'b1;
                first_q <= 1'b1;
            end else if (unit_done) begin
                first_q <= 1'b0;
            end
            if ((state_q == ST_READ) && mem_ack) begin
                data_q <= cfg_q.wide ? mem_rdata : {16'h0000, mem_rdata[15:0]};
            end
            if ((state_q == ST_END) && rem_zero) begin
                busy_q <= 1'b0;
                if (!keep_en) begin
                    ctrl_q[EN_BIT] <= 1'b0;
                end
            end
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = cur_a[0];
        cpu_halt  = 1'b0;
        done_irq  = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_SETUP: cpu_halt = 1'b1;
            ST_READ: begin
                cpu_halt = 1'b1;
                mem_req  = 1'b1;
            end
            ST_WRITE: begin
                cpu_halt = 1'b1;
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = cur_a[1];
            end
            ST_HOLD:  cpu_halt = 1'b1;
            ST_END:   done_irq = rem_zero;
            default:  ;
        endcase
        mem_first  = mem_req && first_q;
        mem_wide   = cfg_q.wide;
        mem_wdata  = data_q;
        ctrl_rdata = ctrl_q;
    end
endmodule

// File: rtl/dma_chan_seq_chk.sv
module dma_chan_seq_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ack,
    input logic              mem_first,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              stall,
    input logic              cpu_halt,
    input logic              done_irq
);
    // R12
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R9
    req_in_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> cpu_halt);

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |=> !done_irq);

    // R11
    done_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |-> $past(mem_req && mem_we && mem_ack));

    // R10
    stall_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_ack && stall) |=> !mem_req);

    // R8
    first_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_first && mem_we) |-> $past(mem_first));
endmodule

bind dma_chan_seq dma_chan_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_ack   (mem_ack),
    .mem_first (mem_first),
    .mem_addr  (mem_addr),
    .stall     (stall),
    .cpu_halt  (cpu_halt),
    .done_irq  (done_irq)
);

// File: tb/tb_dma_chan_seq.sv
`timescale 1ns/1ps
module tb_dma_chan_seq;
    localparam int CLK_NS = 10;
    localparam int CNT_W  = 8;
    localparam int CHUNK  = 112;

    typedef struct packed {
        logic [31:0] a;
        logic [31:0] d;
        logic        f;
    } item_t;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        reg_we = 0;
    logic [1:0]  reg_sel = 0;
    logic [31:0] reg_wdata = 0;
    logic [31:0] ctrl_rdata;
    logic        fifo_req = 0;
    logic        stall = 0;
    logic        mem_req, mem_we, mem_wide, mem_first;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = 0;
    logic        mem_ack = 0;
    logic        cpu_halt, done_irq;

    int checks = 0;
    int errors = 0;
    int n_writes = 0;
    int n_done = 0;
    item_t exp_q[$];
    logic [31:0] mem [256];

    always #(CLK_NS/2) clk = ~clk;

    dma_chan_seq #(.ADDR_W(32), .CNT_W(CNT_W), .FIFO_CHUNK(CHUNK)) dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .ctrl_rdata(ctrl_rdata), .fifo_req(fifo_req),
        .stall(stall), .mem_req(mem_req), .mem_we(mem_we), .mem_wide(mem_wide),
        .mem_first(mem_first), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack), .cpu_halt(cpu_halt),
        .done_irq(done_irq)
    );

    function automatic logic [31:0] pat(input logic [7:0] i);
        return {i ^ 8'hC3, i, i + 8'h3C, ~i};
    endfunction

    function automatic logic [31:0] exp_data(input logic [31:0] a, input logic w);
        logic [31:0] word;
        word = pat(a[9:2]);
        if (w) return word;
        return {16'h0000, a[1] ? word[31:16] : word[15:0]};
    endfunction

    function automatic logic [31:0] step(input logic [31:0] a, input logic [1:0] m, input logic w);
        logic [31:0] sz;
        sz = w ? 32'd4 : 32'd2;
        case (m)
            2'b01:   return a - sz;
            2'b10:   return a;
            default: return a + sz;
        endcase
    endfunction

    function automatic logic [31:0] ctl(input logic en, input logic [2:0] trig, input logic w,
                                       input logic rpt, input logic [1:0] ss, input logic [1:0] ds,
                                       input logic [20:0] cnt);
        return {en, 1'b0, trig, w, rpt, ss, ds, cnt};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // driver: queue the writes a transfer must produce
    task automatic push_run(input logic [31:0] s0, input logic [31:0] d0, input logic [1:0] ss,
                            input logic [1:0] ds, input logic w, input int total, input int chunk);
        logic [31:0] s, d;
        int left, n;
        s = s0; d = d0; left = total;
        while (left > 0) begin
            n = (left > chunk) ? chunk : left;
            if (ss == 2'b11) s = s0;   // R3 reload at each activation
            if (ds == 2'b11) d = d0;
            for (int k = 0; k < n; k++) begin
                exp_q.push_back('{a: d, d: exp_data(s, w), f: (k == 0)});
                s = step(s, ss, w);
                d = step(d, ds, w);
            end
            left -= n;
        end
    endtask

    // memory model and scoreboard monitor
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
        end else if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (!mem_we) begin
                mem_rdata <= exp_data(mem_addr, mem_wide);
            end else begin
                n_writes++;
                if (mem_wide) mem[mem_addr[9:2]] = mem_wdata;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2", "unexpected write addr", {32'h0, mem_addr}, 64'h0);
                end else begin
                    item_t e;
                    e = exp_q.pop_front();
                    chk(mem_addr == e.a, "R3", "write address", {32'h0, mem_addr}, {32'h0, e.a});
                    chk(mem_wdata == e.d, "R4", "write data", {32'h0, mem_wdata}, {32'h0, e.d});
                    chk(mem_first == e.f, "R8", "first flag", {63'h0, mem_first}, {63'h0, e.f});
                end
            end
        end else begin
            mem_ack <= 1'b0;
        end
        if (rst_n && done_irq) n_done++;
    end

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] data);
        tick();
        reg_we = 1; reg_sel = sel; reg_wdata = data;
        tick();
        reg_we = 0;
    endtask

    task automatic wait_done(input int target);
        for (int i = 0; i < 5000; i++) begin
            if (n_done >= target) break;
            tick();
        end
        tick();
    endtask

    task automatic fifo_act();
        tick();
        fifo_req = 1;
        tick();
        fifo_req = 0;
        for (int i = 0; i < 3000; i++) begin
            if (!cpu_halt) break;
            tick();
        end
        repeat (3) tick();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        int w0;
        for (int i = 0; i < 256; i++) mem[i] = pat(8'(i));
        repeat (3) tick();
        // R1 reset state
        chk(ctrl_rdata == 0, "R1", "ctrl after reset", {32'h0, ctrl_rdata}, 64'h0);
        chk(!mem_req && !cpu_halt && !done_irq, "R1", "outputs after reset",
            {61'h0, mem_req, cpu_halt, done_irq}, 64'h0);
        rst_n = 1;
        repeat (2) tick();

        // R4 R2 R9 R11: immediate, 16-bit, inc/inc, 5 units
        wr(2'd0, 32'h000); wr(2'd1, 32'h200);
        push_run(32'h000, 32'h200, 2'b00, 2'b00, 1'b0, 5, 1000);
        wr(2'd2, ctl(1, 3'd0, 0, 0, 2'b00, 2'b00, 21'd5));
        repeat (2) tick();
        chk(cpu_halt, "R9", "halt during transfer", {63'h0, cpu_halt}, 64'h1);
        wait_done(1);
        chk(n_writes == 5, "R6", "immediate unit count", n_writes, 5);
        chk(!ctrl_rdata[31], "R11", "enable cleared", {63'h0, ctrl_rdata[31]}, 64'h0);
        chk(!cpu_halt, "R9", "halt released", {63'h0, cpu_halt}, 64'h0);

        // R3 R4: 32-bit, src decrement, dst fixed, 3 units
        wr(2'd0, 32'h100); wr(2'd1, 32'h300);
        push_run(32'h100, 32'h300, 2'b01, 2'b10, 1'b1, 3, 1000);
        wr(2'd2, ctl(1, 3'd0, 1, 0, 2'b01, 2'b10, 21'd3));
        wait_done(2);
        chk(n_writes == 8, "R3", "dec/fixed count", n_writes, 8);

        // R5: bits above the count mask ignored (0x105 -> 5)
        wr(2'd0, 32'h040); wr(2'd1, 32'h240);
        push_run(32'h040, 32'h240, 2'b00, 2'b00, 1'b1, 5, 1000);
        wr(2'd2, ctl(1, 3'd0, 1, 0, 2'b00, 2'b00, 21'h105));
        wait_done(3);
        chk(n_writes == 13, "R5", "masked count", n_writes, 13);

        // R5: zero count means 2^CNT_W units
        wr(2'd0, 32'h000); wr(2'd1, 32'h200);
        push_run(32'h000, 32'h200, 2'b00, 2'b00, 1'b0, 256, 1000);
        wr(2'd2, ctl(1, 3'd0, 0, 0, 2'b00, 2'b00, 21'd0));
        wait_done(4);
        chk(n_writes == 269, "R5", "zero count length", n_writes, 269);

        // R2: rewriting control while enabled does not restart
        wr(2'd0, 32'h010); wr(2'd1, 32'h280);
        push_run(32'h010, 32'h280, 2'b00, 2'b00, 1'b0, 4, 1000);
        wr(2'd2, ctl(1, 3'd0, 0, 0, 2'b00, 2'b00, 21'd4));
        wr(2'd2, ctl(1, 3'd0, 0, 0, 2'b00, 2'b00, 21'd9));
        wait_done(5);
        repeat (30) tick();
        chk(n_writes == 273, "R2", "no restart on rewrite", n_writes, 273);
        chk(n_done == 5, "R2", "single done on rewrite", n_done, 5);

        // R6: other trigger codes never start
        wr(2'd2, ctl(1, 3'd3, 0, 0, 2'b00, 2'b00, 21'd2));
        repeat (20) tick();
        chk(n_writes == 273 && !cpu_halt, "R6", "code 3 idle", n_writes, 273);
        wr(2'd2, 32'h0);

        // R7 R8 R9: FIFO mode, 256 units in slices, dst reload
        wr(2'd0, 32'h000); wr(2'd1, 32'h200);
        push_run(32'h000, 32'h200, 2'b00, 2'b11, 1'b0, 256, CHUNK);
        wr(2'd2, ctl(1, 3'd7, 0, 0, 2'b00, 2'b11, 21'd0));
        repeat (10) tick();
        chk(n_writes == 273, "R6", "fifo waits for request", n_writes, 273);
        fifo_act();
        chk(n_writes == 385, "R7", "first slice size", n_writes, 385);
        chk(!cpu_halt, "R9", "halt low between slices", {63'h0, cpu_halt}, 64'h0);
        chk(ctrl_rdata[31] && n_done == 5, "R7", "still enabled after slice",
            {63'h0, ctrl_rdata[31]}, 64'h1);
        fifo_act();
        chk(n_writes == 497, "R7", "second slice size", n_writes, 497);
        fifo_act();
        chk(n_writes == 529, "R7", "last slice size", n_writes, 529);
        chk(n_done == 6, "R11", "one done for sliced transfer", n_done, 6);
        chk(!ctrl_rdata[31], "R11", "enable cleared after slices", {63'h0, ctrl_rdata[31]}, 64'h0);

        // R11 R3: repeat with source reload
        wr(2'd0, 32'h020); wr(2'd1, 32'h300);
        push_run(32'h020, 32'h300, 2'b11, 2'b00, 1'b1, 3, CHUNK);
        push_run(32'h020, 32'h30C, 2'b11, 2'b00, 1'b1, 3, CHUNK);
        wr(2'd2, ctl(1, 3'd7, 1, 1, 2'b11, 2'b00, 21'd3));
        fifo_act();
        chk(n_done == 7, "R11", "repeat run done", n_done, 7);
        chk(ctrl_rdata[31], "R11", "repeat keeps enable", {63'h0, ctrl_rdata[31]}, 64'h1);
        fifo_act();
        chk(n_writes == 535 && n_done == 8, "R11", "repeat reloads count", n_writes, 535);
        wr(2'd2, 32'h0);

        // R10: stall between units
        stall = 1;
        wr(2'd0, 32'h060); wr(2'd1, 32'h380);
        push_run(32'h060, 32'h380, 2'b00, 2'b00, 1'b0, 6, 1000);
        w0 = n_writes;
        wr(2'd2, ctl(1, 3'd0, 0, 0, 2'b00, 2'b00, 21'd6));
        repeat (30) tick();
        chk(n_writes == w0 + 1, "R10", "one unit before stall", n_writes, w0 + 1);
        chk(cpu_halt && !mem_req, "R10", "held with halt, no request",
            {62'h0, cpu_halt, mem_req}, 64'h2);
        stall = 0;
        wait_done(9);
        chk(n_writes == w0 + 6, "R10", "resumed to end", n_writes, w0 + 6);

        chk(exp_q.size() == 0, "R12", "scoreboard drained", exp_q.size(), 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule